// File: doc/BRIEF.md
# Printer port register interface

This block is the byte-wide register face of a PC-style standard printer port. A host bus selects data, status or control by a small offset and reads or writes one byte per access. The block does not model a printer. It plays the peripheral's part of the handshake itself. A control write that raises strobe hands the data byte to a byte-output stream and drops busy. Later status reads walk acknowledge and busy through their pulse sequence.

An interrupt line is driven from a pending flag. Only a strobe write made while interrupts are enabled can raise that flag, and any status read clears it. A direction bit in control chooses what a data read returns: an external input latch, or the byte last written. Read data is combinational in the access cycle. Every side effect of an access takes place at the clock edge that accepts it.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, reading offset 1 (status) returns 0xD8, offset 2 (control) returns 0x0C, offset 0 (data) returns 0x00, irq is low and out_valid is low.
- R2: A write to offset 0 stores the byte. A data read returns that byte while control bit 5 (direction) is 0. It returns data_in while bit 5 is 1.
- R3: A control read returns control bits 5..0 with bits 7..6 as 0. Writes to offset 1 (status) leave status unchanged.
- R4: Reads of offsets 3 to 7 return 0xFF. Writes to those offsets change no register.
- R5: A control write with bit 2 (init, inverted sense) equal to 0 sets status to 0xD8, whatever its earlier value.
- R6: A control write with bits 2, 3 and 0 all 1 clears status bit 7 (busy, inverted sense). If the control value held before that write had bit 0 (strobe) equal to 0, out_valid is high for exactly the cycle after the write, carrying the data byte. Otherwise no byte is emitted. A strobe write with bit 3 at 0 neither changes status nor emits a byte.
- R7: A status read returns the current status. If status bit 7 is 0 and control bit 0 is 0 at that read, then a set bit 6 (acknowledge) is cleared. If bit 6 is already clear, bits 6 and 7 are both set.
- R8: A status read in any other situation leaves status unchanged.
- R9: A R6 strobe write sets the pending flag when the control value held before the write has bit 4 (interrupt enable) set. Any status read clears the flag. From the cycle after each access, irq equals the pending flag ANDed with control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | An access is presented this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| data_in | input | 8 | Input latch returned by data reads in read direction |
| irq | output | 1 | Interrupt request |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_data | output | 8 | Emitted byte, meaningful while out_valid is high |

## Verification
Read data is due in the same cycle as the read, so the bench compares it one time unit after driving the access. Status, control, the pending flag and irq change at the accepting edge, and out_valid rises at that same edge. The behavioural model therefore updates at each rising edge. At every falling edge the bench compares irq, out_valid and out_data with the model, so each result is checked in the first cycle it is due. Handshake steps are checked through the value the next status read returns.

// File: rtl/prn_pkg.sv
package prn_pkg;
   localparam int OFS_DATA = 0;
   localparam int OFS_STAT = 1;
   localparam int OFS_CTRL = 2;

   localparam int ST_NBUSY  = 7;
   localparam int ST_ACK    = 6;
   localparam int ST_PAPER  = 5;
   localparam int ST_ONLINE = 4;
   localparam int ST_NERR   = 3;
   localparam int ST_TMO    = 0;

   localparam int CT_DIR  = 5;
   localparam int CT_IEN  = 4;
   localparam int CT_SEL  = 3;
   localparam int CT_INIT = 2;
   localparam int CT_ALF  = 1;
   localparam int CT_STB  = 0;
   localparam int CT_W    = 6;

   localparam logic [7:0]      ST_RESET = 8'hD8;
   localparam logic [CT_W-1:0] CT_RESET = 6'h0C;
endpackage

// File: rtl/prn_ctrl_reg.sv
module prn_ctrl_reg
   import prn_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit EMIT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data_en,
   input  logic              wr_ctrl_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] data_q,
   output logic [CT_W-1:0]   ctl_q,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic emit;

   assign emit = wr_ctrl_en & wdata[CT_INIT] & wdata[CT_SEL] & wdata[CT_STB]
               & ~ctl_q[CT_STB];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         ctl_q  <= CT_RESET;
      end else begin
         if (wr_data_en) data_q <= wdata;
         if (wr_ctrl_en) ctl_q  <= wdata[CT_W-1:0];
      end
   end

   generate
      if (EMIT_REG) begin : g_emit_reg
         logic              vld_q;
         logic [DATA_W-1:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               byte_q <= '0;
            end else begin
               vld_q <= emit;
               if (emit) byte_q <= data_q;
            end
         end
         assign out_valid = vld_q;
         assign out_data  = byte_q;
      end else begin : g_emit_comb
         assign out_valid = emit;
         assign out_data  = data_q;
      end
   endgenerate

   AST_EMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid) else $error("emit pulse longer than one cycle"); // R6
endmodule

// File: rtl/prn_status_hs.sv
module prn_status_hs
   import prn_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl_en,
   input  logic              rd_stat_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CT_W-1:0]   ctl_q,
   output logic [7:0]        stat_q,
   output logic              irq
);
   logic [7:0] stat_n;
   logic       pend_q, pend_n, ien_n, irq_q;

   always_comb begin
      stat_n = stat_q;
      pend_n = pend_q;
      if (wr_ctrl_en) begin
         if (!wdata[CT_INIT]) begin
            stat_n = ST_RESET;
         end else if (wdata[CT_SEL] && wdata[CT_STB]) begin
            stat_n[ST_NBUSY] = 1'b0;
            if (ctl_q[CT_IEN]) pend_n = 1'b1;
         end
      end
      if (rd_stat_en) begin
         pend_n = 1'b0;
         if (!stat_q[ST_NBUSY] && !ctl_q[CT_STB]) begin
            if (stat_q[ST_ACK]) begin
               stat_n[ST_ACK] = 1'b0;
            end else begin
               stat_n[ST_ACK]   = 1'b1;
               stat_n[ST_NBUSY] = 1'b1;
            end
         end
      end
      ien_n = wr_ctrl_en ? wdata[CT_IEN] : ctl_q[CT_IEN];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= ST_RESET;
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         stat_q <= stat_n;
         pend_q <= pend_n;
         irq_q  <= pend_n & ien_n;
      end
   end

   assign irq = irq_q;

   AST_INIT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl_en && !wdata[CT_INIT]) |=> (stat_q == ST_RESET)) else $error("init write"); // R5
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat_en && !stat_q[ST_NBUSY] && !ctl_q[CT_STB] && stat_q[ST_ACK])
      |=> !stat_q[ST_ACK]) else $error("ack step"); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctl_q[CT_IEN]) else $error("irq without enable"); // R9
   AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat_en |=> !irq) else $error("status read left irq"); // R9
endmodule

// File: rtl/prn_read_mux.sv
module prn_read_mux
   import prn_pkg::*;
#(
   parameter int                DATA_W = 8,
   parameter int                ADDR_W = 3,
   parameter logic [DATA_W-1:0] FILL   = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] data_in,
   input  logic [CT_W-1:0]   ctl_q,
   input  logic [7:0]        stat_q,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = FILL;
      if (addr == ADDR_W'(OFS_DATA))
         rdata = ctl_q[CT_DIR] ? data_in : data_q;
      else if (addr == ADDR_W'(OFS_STAT))
         rdata = stat_q;
      else if (addr == ADDR_W'(OFS_CTRL))
         rdata = {{(DATA_W-CT_W){1'b0}}, ctl_q};
   end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
   import prn_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 3,
   parameter bit                EMIT_REG = 1'b1,
   parameter logic [DATA_W-1:0] FILL     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] data_in,
   output logic              irq,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int NUM_OFS = 1 << ADDR_W;

   initial begin
      assert (DATA_W == 8) else $error("status layout needs an 8-bit bus");
      assert (ADDR_W >= 2) else $error("offset field too narrow");
      assert (NUM_OFS > OFS_CTRL) else $error("control offset not reachable");
   end

   logic wr_data_en, wr_ctrl_en, rd_stat_en;
   logic [DATA_W-1:0] data_q;
   logic [CT_W-1:0]   ctl_q;
   logic [7:0]        stat_q;

   assign wr_data_en = bus_sel &  bus_wr & (bus_addr == ADDR_W'(OFS_DATA));
   assign wr_ctrl_en = bus_sel &  bus_wr & (bus_addr == ADDR_W'(OFS_CTRL));
   assign rd_stat_en = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(OFS_STAT));

   prn_ctrl_reg #(.DATA_W(DATA_W), .EMIT_REG(EMIT_REG)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_data_en(wr_data_en), .wr_ctrl_en(wr_ctrl_en),
      .wdata(bus_wdata), .data_q(data_q), .ctl_q(ctl_q),
      .out_valid(out_valid), .out_data(out_data)
   );

   prn_status_hs #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .wr_ctrl_en(wr_ctrl_en), .rd_stat_en(rd_stat_en),
      .wdata(bus_wdata), .ctl_q(ctl_q), .stat_q(stat_q), .irq(irq)
   );

   prn_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILL(FILL)) u_mux (
      .addr(bus_addr), .data_q(data_q), .data_in(data_in),
      .ctl_q(ctl_q), .stat_q(stat_q), .rdata(bus_rdata)
   );

   AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr > ADDR_W'(OFS_CTRL)) |=>
      ($stable(data_q) && $stable(ctl_q) && $stable(stat_q))) else $error("unused write"); // R4
   AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_STAT)) |=> $stable(stat_q))
      else $error("status write took effect"); // R3
endmodule

// File: tb/tb_prn_port_regs.sv
module tb_prn_port_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, wr = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wd = '0, din = '0;
   logic [7:0] rdata, odata;
   logic       irq, ovalid;

   int vectors = 0, fails = 0;
   string cur_req = "R1";

   // behavioural model
   int m_stat, m_ctl, m_data, m_pend, m_valid, m_out;

   always #2 clk = ~clk;

   prn_port_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wd), .bus_rdata(rdata), .data_in(din), .irq(irq),
      .out_valid(ovalid), .out_data(odata)
   );

   always @(posedge clk) begin
      m_valid = 0;
      if (!rst_n) begin
         m_stat = 'hD8; m_ctl = 'h0C; m_data = 0; m_pend = 0; m_out = 0;
      end else if (sel && wr) begin
         if (addr == 0) m_data = wd;
         else if (addr == 2) begin
            if (wd[2] == 0) m_stat = 'hD8;
            else if (wd[3] && wd[0]) begin
               m_stat = m_stat & 'h7F;
               if ((m_ctl & 1) == 0) begin m_valid = 1; m_out = m_data; end
               if ((m_ctl & 'h10) != 0) m_pend = 1;
            end
            m_ctl = wd & 'h3F;
         end
      end else if (sel && !wr && addr == 1) begin
         m_pend = 0;
         if ((m_stat & 'h80) == 0 && (m_ctl & 1) == 0) begin
            if ((m_stat & 'h40) != 0) m_stat = m_stat & 'hBF;
            else m_stat = m_stat | 'hC0;
         end
      end
   end

   function automatic int exp_rd(input int a);
      if (a == 0) return ((m_ctl & 'h20) != 0) ? din : m_data;
      if (a == 1) return m_stat;
      if (a == 2) return m_ctl;
      return 'hFF;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // registered outputs compared every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         check("R9", "irq", irq, (m_pend != 0 && (m_ctl & 'h10) != 0) ? 1 : 0);
         check("R6", "out_valid", ovalid, m_valid);
         if (m_valid != 0) check("R6", "out_data", odata, m_out);
      end
   end

   task automatic acc(input bit w, input int a, input int v);
      @(negedge clk);
      sel = 1'b1; wr = w; addr = a[2:0]; wd = v[7:0];
      #1;
      if (!w) check(cur_req, $sformatf("read ofs %0d", a), rdata, exp_rd(a));
   endtask

   task automatic idle();
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      acc(0, 1, 0); acc(0, 2, 0); acc(0, 0, 0); idle();
      check("R1", "irq after reset", irq, 0);

      cur_req = "R2";
      acc(1, 0, 'hA5); acc(0, 0, 0);
      din = 8'h3C;
      acc(1, 2, 'h2C); acc(0, 0, 0); acc(1, 2, 'h0C); acc(0, 0, 0);

      cur_req = "R3";
      acc(1, 1, 'h00); acc(0, 1, 0); acc(1, 2, 'h3E); acc(0, 2, 0); acc(1, 2, 'h0C);

      cur_req = "R4";
      for (int a = 3; a < 8; a++) begin acc(1, a, 'h00); acc(0, a, 0); end
      acc(0, 0, 0); acc(0, 1, 0); acc(0, 2, 0);

      cur_req = "R6";
      acc(1, 0, 'h41); acc(1, 2, 'h1D); acc(0, 1, 0);
      cur_req = "R9";
      acc(1, 2, 'h1D); idle(); acc(1, 2, 'h1C); idle();
      cur_req = "R7";
      acc(0, 1, 0); acc(0, 1, 0); acc(0, 1, 0);
      cur_req = "R8";
      acc(0, 1, 0);

      cur_req = "R5";
      acc(1, 0, 'h77); acc(1, 2, 'h0D); acc(0, 1, 0); acc(1, 2, 'h08); acc(0, 1, 0);

      cur_req = "R6";
      acc(1, 2, 'h04); acc(1, 2, 'h05); acc(0, 1, 0); idle();
      acc(1, 2, 'h0C); acc(1, 2, 'h0D); acc(1, 2, 'h0D); acc(0, 1, 0);

      cur_req = "R9";
      acc(1, 2, 'h1C); acc(1, 2, 'h1D); acc(1, 2, 'h1D); idle();
      acc(1, 2, 'h0D); idle(); acc(1, 2, 'h1D); idle(); acc(0, 1, 0); idle();
      cur_req = "R8";
      acc(1, 2, 'h1C); acc(0, 1, 0); acc(0, 1, 0); acc(0, 1, 0);
      idle(); idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule